// File: doc/BRIEF.md
# Event Queue Dequeue Arbiter

This block sits between three event queues and the three transfer controllers that serve them. Queue n is paired with controller n and with no other. In each cycle the block looks at which queues hold an entry and which controllers can take a request. It pops the head entry of at most one queue and turns that entry into a transfer request. The request goes to the controller paired with the queue, in the same cycle as the pop. A fixed priority picks among the eligible queues: queue 0 first, queue 2 last. A queue counts as eligible only while its own controller is ready. When a controller is busy, the queues below it can still be served.

Both data paths are valid/ready streams. On the queue side, `q_valid[n]` means the queue holds an entry and `q_head` carries its head. `q_pop[n]` is the ready strobe, and the queue removes its head on a clock edge where the strobe is high. On the controller side, `tc_ready[n]` is the back-pressure input. The block raises `tc_valid[n]` only in a cycle where `tc_ready[n]` is already high, so a request is accepted on the edge where it is offered. For the same reason, a controller must drive its ready without looking at valid. The block also holds a programmable register with one priority level per queue. It drives these levels out on `sys_prio` for use in system bus arbitration.

Top module: `evq_dequeue_arb`

## Requirements
- R1: `q_pop[n]` is high only when `q_valid[n]` and `tc_ready[n]` are both high.
- R2: Among the eligible queues (valid and controller ready), the lowest-numbered queue is dequeued.
- R3: At most one bit of `q_pop` is high in any cycle.
- R4: `tc_valid` equals `q_pop` in every cycle, so a request from queue n reaches only controller n. The `tc_chan` and `tc_pset` slices of a controller that has no request are zero.
- R5: A head entry is 7 bits wide. Bits [5:0] hold the channel number and bit 6 marks a quick-channel event. The request carries the channel number on `tc_chan` (6 bits per controller, controller 0 in the lowest bits). It also carries a parameter-set index on `tc_pset` (7 bits per controller). The index equals the channel number for a normal event and the channel number plus 64 for a quick-channel event.
- R6: When the controller of a higher-priority queue is not ready, the next eligible lower-priority queue is served in that same cycle.
- R7: `sys_prio` packs a 3-bit level per queue, with queue 0 in bits [2:0]. After reset the level of queue n is n. A cycle with `prio_we` high loads `prio_wdata` into the register, and the new value appears after that clock edge. Without `prio_we`, the register keeps its value.
- R8: When no queue is eligible, `q_pop` and `tc_valid` are all zero.
- R9: Entries of one queue reach its controller in the order they entered the queue, one per cycle at most.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| q_valid | input | 3 | Queue n holds at least one entry |
| q_head | input | 21 | Head entries, 7 bits per queue, queue 0 lowest |
| q_pop | output | 3 | Pop strobe, one per queue |
| tc_ready | input | 3 | Controller n can accept a request |
| tc_valid | output | 3 | Request offered to controller n |
| tc_chan | output | 18 | Channel number per controller |
| tc_pset | output | 21 | Parameter-set index per controller |
| prio_we | input | 1 | Load strobe for the priority levels |
| prio_wdata | input | 9 | New priority levels, 3 bits per queue |
| sys_prio | output | 9 | Current priority levels for bus arbitration |

## Verification
The properties assume that `tc_ready` does not wait for `tc_valid`. They also assume that `q_valid` reflects the queue content, so a pop is never taken as consent from an empty queue. The bench keeps to these assumptions. It drives every input on the falling edge, from fixed patterns or from its own FIFO models. Those models lower `q_valid` once their entries are used up. The register checks assume that `prio_we` is held low while reset is active, and the bench does so.

// File: rtl/evq_dqa_pkg.sv
package evq_dqa_pkg;

  // Parameter-set index for a head entry: quick-channel events sit above
  // the block of normal channel sets.
  function automatic logic [31:0] pset_index(input logic quick,
                                             input logic [31:0] chan,
                                             input int unsigned quick_base);
    pset_index = quick ? (chan + quick_base) : chan;
  endfunction

endpackage

// File: rtl/evq_dqa_picker.sv
module evq_dqa_picker #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/evq_dqa_req_build.sv
module evq_dqa_req_build
  import evq_dqa_pkg::*;
#(
  parameter int unsigned CH_W       = 6,
  parameter int unsigned QUICK_BASE = 64,
  parameter int unsigned PS_W       = 7,
  localparam int unsigned EW        = CH_W + 1
) (
  input  logic [EW-1:0]   entry,
  input  logic            sel,
  output logic [CH_W-1:0] chan,
  output logic [PS_W-1:0] pset
);

  logic [31:0] chan_ext;
  logic [31:0] pset_full;

  always_comb begin
    chan_ext  = 32'(entry[CH_W-1:0]);
    pset_full = pset_index(entry[CH_W], chan_ext, QUICK_BASE);
    chan      = sel ? entry[CH_W-1:0] : '0;
    pset      = sel ? pset_full[PS_W-1:0] : '0;
  end

endmodule

// File: rtl/evq_dqa_prio_regs.sv
module evq_dqa_prio_regs #(
  parameter int unsigned NQ   = 3,
  parameter int unsigned PL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NQ*PL_W-1:0] wdata,
  output logic [NQ*PL_W-1:0] levels
);

  logic [NQ*PL_W-1:0] reset_val;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      reset_val[i*PL_W +: PL_W] = PL_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      levels <= reset_val;
    end else if (we) begin
      levels <= wdata;
    end
  end

endmodule

// File: rtl/evq_dequeue_arb.sv
module evq_dequeue_arb #(
  parameter int unsigned NQ         = 3,
  parameter int unsigned CH_W       = 6,
  parameter int unsigned QUICK_BASE = 64,
  parameter int unsigned PL_W       = 3,
  localparam int unsigned EW        = CH_W + 1,
  localparam int unsigned PS_W      = $clog2(QUICK_BASE + (1 << CH_W))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NQ-1:0]      q_valid,
  input  logic [NQ*EW-1:0]   q_head,
  output logic [NQ-1:0]      q_pop,
  input  logic [NQ-1:0]      tc_ready,
  output logic [NQ-1:0]      tc_valid,
  output logic [NQ*CH_W-1:0] tc_chan,
  output logic [NQ*PS_W-1:0] tc_pset,
  input  logic               prio_we,
  input  logic [NQ*PL_W-1:0] prio_wdata,
  output logic [NQ*PL_W-1:0] sys_prio
);

  logic [NQ-1:0] eligible;
  logic [NQ-1:0] grant;

  assign eligible = q_valid & tc_ready;

  evq_dqa_picker #(.N(NQ)) u_pick (
    .req (eligible),
    .gnt (grant)
  );

  assign q_pop    = grant;
  assign tc_valid = grant;

  for (genvar g = 0; g < NQ; g++) begin : g_lane
    evq_dqa_req_build #(
      .CH_W       (CH_W),
      .QUICK_BASE (QUICK_BASE),
      .PS_W       (PS_W)
    ) u_build (
      .entry (q_head[g*EW +: EW]),
      .sel   (grant[g]),
      .chan  (tc_chan[g*CH_W +: CH_W]),
      .pset  (tc_pset[g*PS_W +: PS_W])
    );
  end

  evq_dqa_prio_regs #(.NQ(NQ), .PL_W(PL_W)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (prio_we),
    .wdata  (prio_wdata),
    .levels (sys_prio)
  );

endmodule

// File: rtl/evq_dequeue_arb_chk.sv
module evq_dequeue_arb_chk #(
  parameter int unsigned NQ   = 3,
  parameter int unsigned PL_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NQ-1:0]      q_valid,
  input logic [NQ-1:0]      tc_ready,
  input logic [NQ-1:0]      q_pop,
  input logic [NQ-1:0]      tc_valid,
  input logic               prio_we,
  input logic [NQ*PL_W-1:0] prio_wdata,
  input logic [NQ*PL_W-1:0] sys_prio
);

  p_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop & ~(q_valid & tc_ready)) == '0);

  for (genvar i = 1; i < NQ; i++) begin : g_prio
    p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_pop[i] |-> ((q_valid & tc_ready & NQ'((1 << i) - 1)) == '0));
  end

  p_single_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop));

  p_paired_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_valid == q_pop);

  p_serve_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid[0] && !tc_ready[0] && q_valid[1] && tc_ready[1]) |-> q_pop[1]);

  p_prio_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prio_we |=> (sys_prio == $past(prio_wdata)));

  p_prio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_we |=> $stable(sys_prio));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_valid & tc_ready) == '0) |-> (q_pop == '0 && tc_valid == '0));

endmodule

bind evq_dequeue_arb evq_dequeue_arb_chk #(.NQ(NQ), .PL_W(PL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_valid    (q_valid),
  .tc_ready   (tc_ready),
  .q_pop      (q_pop),
  .tc_valid   (tc_valid),
  .prio_we    (prio_we),
  .prio_wdata (prio_wdata),
  .sys_prio   (sys_prio)
);

// File: tb/evq_dequeue_arb_bench.sv
module evq_dequeue_arb_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  q_valid = '0;
  logic [20:0] q_head = '0;
  logic [2:0]  q_pop;
  logic [2:0]  tc_ready = '0;
  logic [2:0]  tc_valid;
  logic [17:0] tc_chan;
  logic [20:0] tc_pset;
  logic        prio_we = 1'b0;
  logic [8:0]  prio_wdata = '0;
  logic [8:0]  sys_prio;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evq_dequeue_arb u_evq_dequeue_arb (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_head(q_head), .q_pop(q_pop),
    .tc_ready(tc_ready), .tc_valid(tc_valid), .tc_chan(tc_chan), .tc_pset(tc_pset),
    .prio_we(prio_we), .prio_wdata(prio_wdata), .sys_prio(sys_prio)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ent(input bit quick, input int ch);
    ent = {quick, 6'(ch)};
  endfunction

  task automatic drive(input logic [2:0] v, input logic [2:0] r,
                       input logic [6:0] h0, input logic [6:0] h1, input logic [6:0] h2);
    @(negedge clk);
    q_valid  = v;
    tc_ready = r;
    q_head   = {h2, h1, h0};
    #1;
  endtask

  task automatic t_reset;
    drive(3'b000, 3'b111, '0, '0, '0);
    chk(q_pop == 3'b000, "R8", int'(q_pop), 0);
    chk(tc_valid == 3'b000, "R8", int'(tc_valid), 0);
    chk(sys_prio == {3'd2, 3'd1, 3'd0}, "R7", int'(sys_prio), int'({3'd2, 3'd1, 3'd0}));
  endtask

  task automatic t_single;
    for (int q = 0; q < 3; q++) begin
      drive(3'(1 << q), 3'b111, ent(0, 11), ent(0, 22), ent(0, 33));
      chk(q_pop == 3'(1 << q), "R1", int'(q_pop), 1 << q);
      chk(tc_valid == q_pop, "R4", int'(tc_valid), int'(q_pop));
      chk(tc_chan[q*6 +: 6] == 6'(11 * (q + 1)), "R5", int'(tc_chan[q*6 +: 6]), 11 * (q + 1));
      chk((tc_chan & ~(18'h3f << (q*6))) == '0, "R4", int'(tc_chan), int'(tc_chan[q*6 +: 6]) << (q*6));
    end
  endtask

  task automatic t_not_ready;
    drive(3'b001, 3'b110, ent(0, 5), '0, '0);
    chk(q_pop == 3'b000, "R1", int'(q_pop), 0);
    drive(3'b110, 3'b001, '0, ent(0, 1), ent(0, 2));
    chk(tc_valid == 3'b000, "R8", int'(tc_valid), 0);
  endtask

  task automatic t_priority;
    drive(3'b111, 3'b111, ent(0, 1), ent(0, 2), ent(0, 3));
    chk(q_pop == 3'b001, "R2", int'(q_pop), 1);
    chk($countones(q_pop) <= 1, "R3", $countones(q_pop), 1);
    drive(3'b110, 3'b111, ent(0, 1), ent(0, 2), ent(0, 3));
    chk(q_pop == 3'b010, "R2", int'(q_pop), 2);
  endtask

  task automatic t_skip;
    drive(3'b111, 3'b110, ent(0, 1), ent(0, 2), ent(0, 3));
    chk(q_pop == 3'b010, "R6", int'(q_pop), 2);
    drive(3'b111, 3'b100, ent(0, 1), ent(0, 2), ent(0, 3));
    chk(q_pop == 3'b100, "R6", int'(q_pop), 4);
    chk(tc_chan[12 +: 6] == 6'd3, "R6", int'(tc_chan[12 +: 6]), 3);
  endtask

  task automatic t_pset;
    drive(3'b010, 3'b111, '0, ent(1, 5), '0);
    chk(tc_pset[7 +: 7] == 7'd69, "R5", int'(tc_pset[7 +: 7]), 69);
    drive(3'b100, 3'b111, '0, '0, ent(0, 63));
    chk(tc_pset[14 +: 7] == 7'd63, "R5", int'(tc_pset[14 +: 7]), 63);
    chk(tc_pset[6:0] == 7'd0, "R4", int'(tc_pset[6:0]), 0);
  endtask

  task automatic t_prio_write;
    @(negedge clk);
    prio_we    = 1'b1;
    prio_wdata = 9'b101_011_110;
    @(negedge clk);
    prio_we    = 1'b0;
    prio_wdata = 9'b000_000_001;
    #1;
    chk(sys_prio == 9'b101_011_110, "R7", int'(sys_prio), int'(9'b101_011_110));
    @(negedge clk);
    #1;
    chk(sys_prio == 9'b101_011_110, "R7", int'(sys_prio), int'(9'b101_011_110));
  endtask

  // FIFO models per queue; the bench presents heads and advances on pops.
  task automatic run_drain(input logic [2:0] rdy, input int ncyc,
                           input int exp_q[], input int exp_ps[]);
    logic [6:0] mq[3][4];
    int hd[3];
    int cn[3];
    int got = 0;
    mq[0][0] = ent(0, 1); mq[0][1] = ent(0, 2); cn[0] = 2;
    mq[1][0] = ent(0, 10); cn[1] = 1;
    mq[2][0] = ent(1, 3); mq[2][1] = ent(0, 4); cn[2] = 2;
    for (int q = 0; q < 3; q++) hd[q] = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      tc_ready = rdy;
      for (int q = 0; q < 3; q++) begin
        q_valid[q] = hd[q] < cn[q];
        q_head[q*7 +: 7] = (hd[q] < cn[q]) ? mq[q][hd[q]] : 7'd0;
      end
      #1;
      for (int q = 0; q < 3; q++) begin
        if (q_pop[q]) begin
          if (got < exp_q.size()) begin
            chk(q == exp_q[got], "R9", q, exp_q[got]);
            chk(int'(tc_pset[q*7 +: 7]) == exp_ps[got], "R9", int'(tc_pset[q*7 +: 7]), exp_ps[got]);
          end else begin
            chk(1'b0, "R9", q, -1);
          end
          got++;
          hd[q]++;
        end
      end
    end
    chk(got == exp_q.size(), "R9", got, exp_q.size());
  endtask

  task automatic t_fifo;
    run_drain(3'b111, 8, '{0, 0, 1, 2, 2}, '{1, 2, 10, 67, 4});
    run_drain(3'b110, 6, '{1, 2, 2}, '{10, 67, 4});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_not_ready();
    t_priority();
    t_skip();
    t_pset();
    t_prio_write();
    t_fifo();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule